// File: doc/BRIEF.md
# Parallel Flash Operation Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash bus and turns single high-level requests into the bus traffic the device expects. A request names an operation, a start address and a length. The block then runs the matching series of timed write and read cycles. Where the device needs time to finish internally, the block polls it with repeated reads until the toggle bit stops changing. Five operations are handled: streaming bytes into the array, erasing one sector, erasing the whole device, and switching write protection on or off. Protection is switched by a fixed series of reads at special addresses.

Requests arrive on a valid/ready handshake and are taken only while the block is idle. Bytes to be programmed are pulled one at a time from a source port. Bytes equal to the erased value are passed over without touching the bus. Every request ends with a one-cycle completion pulse that carries an error flag. The flag is raised for a malformed request, an unknown operation code or a poll that never settles.

Top module: `pfs_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0, and both fl_we_n and fl_oe_n are 1.
- R2: Operation code 0 (program) reads req_len bytes from the source, one src_rd pulse per byte. For each byte not equal to 0xFF it writes 0x10 and then the byte to the current address, and polls for completion before it fetches the next byte.
- R3: During program, a source byte of 0xFF causes no bus cycle, but the target address still advances by one. A program request with length 0 completes at once without error.
- R4: Operation code 1 (sector erase) writes 0x20 to address 0, then 0xD0 to req_addr, then polls.
- R5: Operation code 2 (chip erase) writes 0x30 twice to address 0. It then waits at least DELAY_CYC clock cycles before the first poll read.
- R6: A chip erase request whose req_addr is not 0, or whose req_len is not 2^AW, completes with err=1 and makes no bus cycle.
- R7: Operation code 3 (protect on) performs exactly seven reads and no writes, at 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419, 0x040A in that order.
- R8: Operation code 4 (protect off) performs the same first six reads as R7, and its seventh read is at 0x041A.
- R9: Polling reads address 0 repeatedly. It ends without error at the first read whose data bit 6 equals bit 6 of the read just before it, so at least two reads are always made.
- R10: If POLL_LIMIT poll reads pass without two equal consecutive bit-6 values, the operation ends with err=1 after exactly POLL_LIMIT reads.
- R11: done is a single-cycle pulse, and err is 1 only together with done. req_ready is 0 from the cycle after acceptance until after done. Operation codes 5 to 7 complete with err=1 and make no bus cycle.
- R12: fl_we_n and fl_oe_n are never low together. Every low pulse lasts exactly STROBE clock cycles, and fl_addr does not change while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_op | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 protect on, 4 protect off) |
| req_addr | input | AW | Start or sector address |
| req_len | input | AW+1 | Byte count |
| src_rd | output | 1 | Consumes src_data this cycle |
| src_data | input | 8 | Next byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Data driven to the flash |
| fl_din | input | 8 | Data returned by the flash |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
A wrong sequencer state shows up at the flash pins within one bus cycle as a wrong address, wrong data byte or wrong strobe kind. For that reason, every operation's full bus transcript is compared event by event against a list the bench builds from the requirements. A poll tracker that miscounts is visible as one read too many or too few before done, and that is seen in the same transcript. A broken delay counter or a broken end-of-request path shows up either as a short gap before the first poll read or as a done pulse that is missing or doubled, within the same request.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_SECT   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CMD, S_DAT, S_WAIT, S_POLL, S_PROT, S_DONE
  } st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} ph_e;

  localparam logic [7:0] ERASED_VAL = 8'hFF;
  localparam logic [7:0] CMD_PROG   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h20;
  localparam logic [7:0] CMD_CONF   = 8'hD0;
  localparam logic [7:0] CMD_CHIP   = 8'h30;

  // Address of read number idx in the protection sequence
  function automatic logic [15:0] lock_ofs(input logic [2:0] idx, input logic unlock);
    case (idx)
      3'd0:    lock_ofs = 16'h1823;
      3'd1:    lock_ofs = 16'h1820;
      3'd2:    lock_ofs = 16'h1822;
      3'd3:    lock_ofs = 16'h0418;
      3'd4:    lock_ofs = 16'h041B;
      3'd5:    lock_ofs = 16'h0419;
      default: lock_ofs = unlock ? 16'h041A : 16'h040A;
    endcase
  endfunction

  function automatic logic [7:0] first_byte(input op_e op);
    case (op)
      OP_PROG: first_byte = CMD_PROG;
      OP_SECT: first_byte = CMD_SECT;
      default: first_byte = CMD_CHIP;
    endcase
  endfunction

  function automatic logic [7:0] second_byte(input op_e op, input logic [7:0] dat);
    case (op)
      OP_PROG: second_byte = dat;
      OP_SECT: second_byte = CMD_CONF;
      default: second_byte = CMD_CHIP;
    endcase
  endfunction

  function automatic logic toggle_of(input logic [7:0] rd);
    toggle_of = rd[6];
  endfunction

endpackage

// File: rtl/pfs_buscyc.sv
module pfs_buscyc
  import pfs_pkg::*;
#(
  parameter int AW     = 19,
  parameter int SETUP  = 1,
  parameter int STROBE = 2,
  parameter int HOLD   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          busy,
  output logic          fin,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int CW = $clog2(SETUP + STROBE + HOLD + 1);

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wr_q;
  wire           phase_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
      rdata  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          addr_q <= addr;
          data_q <= wdata;
          wr_q   <= wr;
          ph     <= PH_SETUP;
          cnt    <= CW'(SETUP - 1);
        end
        PH_SETUP: if (phase_end) begin
          ph  <= PH_STRB;
          cnt <= CW'(STROBE - 1);
        end else cnt <= cnt - 1'b1;
        PH_STRB: if (phase_end) begin
          ph  <= PH_HOLD;
          cnt <= CW'(HOLD - 1);
          if (!wr_q) rdata <= fl_din;
        end else cnt <= cnt - 1'b1;
        default: if (phase_end) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign fin     = (ph == PH_HOLD) && phase_end;
  assign fl_addr = addr_q;
  assign fl_dout = data_q;
  assign fl_we_n = !((ph == PH_STRB) && wr_q);
  assign fl_oe_n = !((ph == PH_STRB) && !wr_q);

  // Checker state: length of the current strobe-low run
  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!fl_we_n || !fl_oe_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we_n || fl_oe_n); // R12
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_we_n) || $rose(fl_oe_n)) |-> (low_run == CW'(STROBE))); // R12
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> $stable(fl_addr)); // R12
endmodule

// File: rtl/pfs_poll.sv
module pfs_poll
  import pfs_pkg::*;
#(
  parameter int LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sample,
  input  logic [7:0] rd_byte,
  output logic       settled,
  output logic       timeout
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          seen;
  logic          prev;
  logic [CW-1:0] cnt;
  wire           cur = toggle_of(rd_byte);

  assign settled = sample && seen && (cur == prev);
  assign timeout = sample && !settled && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      prev <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      seen <= 1'b0;
      cnt  <= '0;
    end else if (sample) begin
      seen <= 1'b1;
      prev <= cur;
      cnt  <= cnt + 1'b1;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt < CW'(LIMIT))); // R10
  AST_SETTLE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (cnt != '0)); // R9
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int AW         = 19,
  parameter int SETUP      = 1,
  parameter int STROBE     = 2,
  parameter int HOLD       = 1,
  parameter int DELAY_CYC  = 2500,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [AW:0]   req_len,
  output logic          src_rd,
  input  logic [7:0]    src_data,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int LW = AW + 1;
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam logic [LW-1:0] DEV_BYTES = {1'b1, {AW{1'b0}}};

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic [7:0]    byte_q;
  logic [2:0]    pidx;
  logic [DW-1:0] dly;
  logic          pend;
  logic          err_q;

  // Named internal events
  logic          cyc_start, cyc_wr, cyc_busy, cyc_fin;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data, cyc_rdata;
  logic          poll_settled, poll_timeout;
  wire           bus_state = (st == S_CMD) || (st == S_DAT) || (st == S_POLL) || (st == S_PROT);
  wire           last_byte = (left_q == LW'(1));
  wire           chip_ok   = (req_addr == '0) && (req_len == DEV_BYTES);

  assign cyc_start = bus_state && !pend && !cyc_busy;
  assign cyc_wr    = (st == S_CMD) || (st == S_DAT);

  always_comb begin
    cyc_addr = '0;
    cyc_data = '0;
    case (st)
      S_CMD: begin
        cyc_addr = (op_q == OP_PROG) ? addr_q : '0;
        cyc_data = first_byte(op_q);
      end
      S_DAT: begin
        cyc_addr = ((op_q == OP_PROG) || (op_q == OP_SECT)) ? addr_q : '0;
        cyc_data = second_byte(op_q, byte_q);
      end
      S_PROT:  cyc_addr = AW'(lock_ofs(pidx, op_q == OP_UNLOCK));
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      left_q <= '0;
      byte_q <= '0;
      pidx   <= '0;
      dly    <= '0;
      pend   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cyc_start) pend <= 1'b1;
      else if (cyc_fin) pend <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          left_q <= req_len;
          pidx   <= '0;
          err_q  <= 1'b0;
          case (op_e'(req_op))
            OP_PROG:   st <= (req_len == '0) ? S_DONE : S_FETCH;
            OP_SECT:   st <= S_CMD;
            OP_CHIP:   begin st <= chip_ok ? S_CMD : S_DONE; err_q <= !chip_ok; end
            OP_LOCK,
            OP_UNLOCK: st <= S_PROT;
            default:   begin st <= S_DONE; err_q <= 1'b1; end
          endcase
        end
        S_FETCH: begin
          byte_q <= src_data;
          if (src_data == ERASED_VAL) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (last_byte) st <= S_DONE;
          end else st <= S_CMD;
        end
        S_CMD: if (cyc_fin) st <= S_DAT;
        S_DAT: if (cyc_fin) begin
          if (op_q == OP_CHIP) begin
            st  <= S_WAIT;
            dly <= DW'(DELAY_CYC - 1);
          end else st <= S_POLL;
        end
        S_WAIT: if (dly == '0) st <= S_POLL;
                else dly <= dly - 1'b1;
        S_POLL: if (poll_settled) begin
          if (op_q == OP_PROG) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            st     <= last_byte ? S_DONE : S_FETCH;
          end else st <= S_DONE;
        end else if (poll_timeout) begin
          st    <= S_DONE;
          err_q <= 1'b1;
        end
        S_PROT: if (cyc_fin) begin
          if (pidx == 3'd6) st <= S_DONE;
          else pidx <= pidx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign src_rd    = (st == S_FETCH);
  assign done      = (st == S_DONE);
  assign err       = done && err_q;

  pfs_buscyc #(.AW(AW), .SETUP(SETUP), .STROBE(STROBE), .HOLD(HOLD)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .wr(cyc_wr), .addr(cyc_addr),
    .wdata(cyc_data), .busy(cyc_busy), .fin(cyc_fin), .rdata(cyc_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  pfs_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(st != S_POLL), .sample(cyc_fin && (st == S_POLL)),
    .rd_byte(cyc_rdata), .settled(poll_settled), .timeout(poll_timeout)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R11
  AST_SRC_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (op_q == OP_PROG)); // R2
  AST_PROT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROT) |-> fl_we_n); // R7
  AST_CHIP_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_POLL) && ($past(st) == S_WAIT)) |-> ($past(dly) == '0)); // R5
  AST_POLL_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_POLL) && !fl_oe_n) |-> (fl_addr == '0)); // R9
endmodule

// File: tb/test_pfs_seq.sv
`timescale 1ns/1ps
module test_pfs_seq;
  localparam int AW = 19, SETUP = 1, STROBE = 2, HOLD = 1;
  localparam int DELAY_CYC = 2500, POLL_LIMIT = 64;
  localparam int NLOG = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0] req_len = '0;
  logic src_rd, done, err;
  logic [7:0] src_data;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;
  logic fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  pfs_seq #(.AW(AW), .SETUP(SETUP), .STROBE(STROBE), .HOLD(HOLD),
            .DELAY_CYC(DELAY_CYC), .POLL_LIMIT(POLL_LIMIT)) i_pfs_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .src_rd(src_rd),
    .src_data(src_data), .done(done), .err(err), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_din(fl_din), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Byte source
  logic [7:0] src_mem [0:31];
  int src_idx = 0;
  assign src_data = src_mem[src_idx[4:0]];
  always @(posedge clk) if (src_rd) src_idx <= src_idx + 1;

  // Flash model, sampled on the falling edge
  logic tog = 1'b0, stuck = 1'b0, prev_we = 1'b1, prev_oe = 1'b1;
  logic [7:0] last_wd = 8'h00;
  int busy_cfg = 0, busy_left = 0, low_cnt = 0, strobe_bad = 0, cyc = 0;
  int last_wr_cyc = 0, first_rd_cyc = -1;
  logic log_w [0:NLOG-1];
  logic [AW-1:0] log_a [0:NLOG-1];
  logic [7:0] log_d [0:NLOG-1];
  int n_log = 0;
  assign fl_din = {1'b0, tog, 6'b0};

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!fl_we_n && !fl_oe_n) strobe_bad++;
      if (!fl_we_n || !fl_oe_n) low_cnt++;
      else if (!prev_we || !prev_oe) begin
        if (low_cnt != STROBE) strobe_bad++;
        low_cnt = 0;
      end
      if (!prev_we && fl_we_n) begin
        if (n_log < NLOG) begin log_w[n_log] = 1'b1; log_a[n_log] = fl_addr; log_d[n_log] = fl_dout; end
        n_log++;
        last_wr_cyc = cyc;
        if (last_wd == 8'h10 || fl_dout == 8'hD0 || (fl_dout == 8'h30 && last_wd == 8'h30))
          busy_left = busy_cfg;
        last_wd = fl_dout;
      end
      if (!prev_oe && fl_oe_n) begin
        if (n_log < NLOG) begin log_w[n_log] = 1'b0; log_a[n_log] = fl_addr; log_d[n_log] = 8'h00; end
        n_log++;
        if (first_rd_cyc < 0) first_rd_cyc = cyc;
        if (stuck) tog = ~tog;
        else if (busy_left > 0) begin tog = ~tog; busy_left--; end
      end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  // Expected transcript
  logic exp_w [0:NLOG-1];
  logic [AW-1:0] exp_a [0:NLOG-1];
  logic [7:0] exp_d [0:NLOG-1];
  int n_exp = 0;
  task automatic push(input logic w, input logic [AW-1:0] a, input logic [7:0] d);
    if (n_exp < NLOG) begin exp_w[n_exp] = w; exp_a[n_exp] = a; exp_d[n_exp] = d; end
    n_exp++;
  endtask
  task automatic push_poll(input int nrd);
    for (int k = 0; k < nrd; k++) push(1'b0, '0, 8'h00);
  endtask
  function automatic logic [15:0] guard_addr(input int k, input bit off);
    logic [15:0] common [0:5];
    common = '{16'h1823, 16'h1820, 16'h1822, 16'h0418, 16'h041B, 16'h0419};
    if (k < 6) return common[k];
    return off ? 16'h041A : 16'h040A;
  endfunction
  task automatic build(input int op, input logic [AW-1:0] a, input int len);
    n_exp = 0;
    case (op)
      0: for (int i = 0; i < len; i++)
           if (src_mem[i] != 8'hFF) begin
             push(1'b1, a + AW'(i), 8'h10);
             push(1'b1, a + AW'(i), src_mem[i]);
             push_poll(stuck ? POLL_LIMIT : busy_cfg + 2);
           end
      1: begin push(1'b1, '0, 8'h20); push(1'b1, a, 8'hD0); push_poll(busy_cfg + 2); end
      2: begin push(1'b1, '0, 8'h30); push(1'b1, '0, 8'h30); push_poll(busy_cfg + 2); end
      3, 4: for (int k = 0; k < 7; k++) push(1'b0, AW'(guard_addr(k, op == 4)), 8'h00);
      default: ;
    endcase
  endtask

  task automatic run(input int op, input logic [AW-1:0] a, input logic [AW:0] len,
                     input bit exp_err, input string req);
    int w;
    bit ok;
    int bad;
    @(posedge clk);
    n_log = 0; first_rd_cyc = -1; src_idx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11", "ready after accept", req_ready, 0);
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(err == exp_err, req, "err flag", err, exp_err);
    @(negedge clk);
    chk(!done && req_ready, "R11", "done single pulse / ready back", {done, req_ready}, 1);
    ok = (n_log == n_exp);
    bad = -1;
    for (int i = 0; i < n_exp && i < NLOG && ok; i++)
      if (log_w[i] != exp_w[i] || log_a[i] != exp_a[i] || log_d[i] != exp_d[i]) begin ok = 0; bad = i; end
    if (bad >= 0)
      chk(ok, req, $sformatf("bus event %0d {w,addr,data}", bad),
          {log_w[bad], log_a[bad], log_d[bad]}, {exp_w[bad], exp_a[bad], exp_d[bad]});
    else chk(ok, req, "bus event count", n_log, n_exp);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int op, len;
    logic [AW-1:0] a;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) src_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(req_ready && !done && fl_we_n && fl_oe_n, "R1", "in reset", {req_ready, done, fl_we_n, fl_oe_n}, 4'b1011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && fl_we_n && fl_oe_n, "R1", "after reset", {req_ready, done, fl_we_n, fl_oe_n}, 4'b1011);

    // R2 R3: mixed bytes with skipped erased values
    src_mem[0] = 8'h12; src_mem[1] = 8'hFF; src_mem[2] = 8'h34; src_mem[3] = 8'hFF; src_mem[4] = 8'hFF; src_mem[5] = 8'h10;
    busy_cfg = 2; build(0, 19'h00100, 6); run(0, 19'h00100, 6, 0, "R2");
    // R3: all erased values, and empty request
    for (int i = 0; i < 3; i++) src_mem[i] = 8'hFF;
    build(0, 19'h00200, 3); run(0, 19'h00200, 3, 0, "R3");
    build(0, 19'h00200, 0); run(0, 19'h00200, 0, 0, "R3");
    // R4
    busy_cfg = 3; build(1, 19'h12345, 0); run(1, 19'h12345, 0, 0, "R4");
    // R5
    busy_cfg = 1; build(2, '0, 0); run(2, '0, 20'h80000, 0, "R5");
    chk(first_rd_cyc - last_wr_cyc >= DELAY_CYC, "R5", "erase delay cycles", first_rd_cyc - last_wr_cyc, DELAY_CYC);
    // R6
    n_exp = 0; run(2, '0, 20'd100, 1, "R6");
    n_exp = 0; run(2, 19'h00001, 20'h80000, 1, "R6");
    // R7 R8
    build(3, '0, 0); run(3, '0, 0, 0, "R7");
    build(4, '0, 0); run(4, '0, 0, 0, "R8");
    // R11 illegal codes
    n_exp = 0; run(5, '0, 0, 1, "R11");
    n_exp = 0; run(7, '0, 5, 1, "R11");
    // R9: device already idle, exactly two reads
    busy_cfg = 0; src_mem[0] = 8'hA5; build(0, 19'h7FFF0, 1); run(0, 19'h7FFF0, 1, 0, "R9");
    // R10: toggle never settles
    stuck = 1'b1; src_mem[0] = 8'h55; build(0, 19'h00005, 1); run(0, 19'h00005, 1, 1, "R10");
    stuck = 1'b0;

    // Random mix
    for (int it = 0; it < 24; it++) begin
      op = int'($urandom % 5);
      busy_cfg = int'($urandom % 5);
      a = AW'($urandom % 32'h7FF00);
      len = 1 + int'($urandom % 12);
      for (int i = 0; i < len; i++) src_mem[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      build(op, a, len);
      case (op)
        0: run(0, a, 20'(len), 0, "R2");
        1: run(1, a, 20'(len), 0, "R4");
        2: run(2, '0, 20'h80000, 0, "R5");
        3: run(3, a, 20'(len), 0, "R7");
        default: run(4, a, 20'(len), 0, "R8");
      endcase
    end

    chk(strobe_bad == 0, "R12", "strobe overlap or width violations", strobe_bad, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule